// File: doc/BRIEF.md
# DMA Channel Address and Enable Controller

This block is the control half of one high-speed DMA channel. Software loads a source address, a destination address, a transfer count and a configuration word through a simple register write port, then sets the enable bit. Each hardware trigger accepted while the channel is enabled produces one transfer descriptor: source, destination, transfer size and the dual/single address flag. A bus master outside this block moves the data and answers with a done pulse.

On each done pulse the block moves each address by the step its two-bit mode field selects and decrements the count. When the count reaches zero, the block clears the enable bit and refuses later triggers. While the channel is enabled, the address, configuration and count registers are write-protected. A trigger that arrives during a transfer is held as pending and served once that transfer ends.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, en_o and busy_o are 0, both addresses and the count are 0, and both address modes are fixed.
- R2: Address mode 2'b00 (fixed) leaves the address unchanged after a transfer.
- R3: Address mode 2'b01 subtracts the step after each transfer and never reloads.
- R4: Address mode 2'b10 adds the step after each transfer. When the count reaches zero, it restores the address held at enable time.
- R5: Address mode 2'b11 adds the step after each transfer and never reloads.
- R6: Size code 2'b00 gives a 1-byte step, 2'b01 a 2-byte step, and 2'b10 or 2'b11 a 4-byte step. xfer_size_o carries the configured code.
- R7: A trigger starts a transfer only while en_o is 1. Triggers while disabled have no effect.
- R8: While en_o is 1, writes to select 0 (source), 1 (destination), 2 (count) and 3 (configuration) are ignored. Select 4 bit 0 writes the enable bit at all times.
- R9: A done pulse that brings the count from 1 to 0 clears en_o on the following cycle.
- R10: The configuration word uses bits [1:0] for the source mode, [3:2] for the destination mode, [5:4] for the size and [6] for dual mode. With bit 6 at 0, xfer_dual_o is 0 and the destination address is never updated.
- R11: A trigger received while busy_o is 1 is kept as pending. Its transfer starts once the current done pulse has been taken.
- R12: busy_o rises on the cycle after acceptance, stays high until done, and falls on the cycle after xfer_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select: 0 src, 1 dst, 2 count, 3 config, 4 enable |
| wr_data_i | input | AW | Write data |
| trig_i | input | 1 | Hardware transfer request |
| xfer_done_i | input | 1 | Bus master finished the current transfer |
| xfer_req_o | output | 1 | Descriptor valid |
| xfer_src_o | output | AW | Descriptor source address |
| xfer_dst_o | output | AW | Descriptor destination address |
| xfer_size_o | output | 2 | Descriptor size code |
| xfer_dual_o | output | 1 | Descriptor uses dual-address mode |
| busy_o | output | 1 | Transfer in progress |
| en_o | output | 1 | Channel enable bit |

## Verification
The assertions check the following on every cycle:
- no transfer starts while the channel is disabled;
- done always ends busy;
- the descriptor holds still during a transfer of an enabled channel;
- fixed-mode sources and single-mode destinations do not move on done;
- the last transfer clears the enable bit.

Exact address sequences for each mode and step, reload against no reload after a block, write protection of the registers, and the serving of a pending trigger can only be shown by the bench's scenarios. The bench compares each descriptor against values it computes itself.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    AM_FIXED   = 2'b00,
    AM_DEC     = 2'b01,
    AM_INC_RLD = 2'b10,
    AM_INC     = 2'b11
  } amode_e;

  typedef struct packed {
    logic       dual;
    logic [1:0] size;
    amode_e     dst_mode;
    amode_e     src_mode;
  } chan_cfg_t;

  localparam int unsigned CFG_W = $bits(chan_cfg_t);

  localparam logic [2:0] SEL_SRC = 3'd0;
  localparam logic [2:0] SEL_DST = 3'd1;
  localparam logic [2:0] SEL_CNT = 3'd2;
  localparam logic [2:0] SEL_CFG = 3'd3;
  localparam logic [2:0] SEL_EN  = 3'd4;

  function automatic logic [2:0] step_bytes(input logic [1:0] size);
    case (size)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          snap_i,
  input  logic          step_i,
  input  logic          blk_end_i,
  input  amode_e        mode_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, shadow_q, delta;

  assign delta = {{(AW-3){1'b0}}, step_bytes(size_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= load_val_i;
    end else if (step_i) begin
      case (mode_i)
        AM_DEC:     addr_q <= addr_q - delta;
        AM_INC_RLD: addr_q <= blk_end_i ? shadow_q : addr_q + delta;
        AM_INC:     addr_q <= addr_q + delta;
        default:    addr_q <= addr_q;
      endcase
    end
  end

  // initial address kept for reload mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (snap_i) shadow_q <= addr_q;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_we_i,
  input  logic             en_wdata_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             trig_i,
  input  logic             done_i,
  output logic             en_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             step_o,
  output logic             blk_end_o,
  output logic             snap_o
);
  logic en_q, en_d, busy_q, busy_d, pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic accept, finish, last;

  assign accept = en_q & ~busy_q & (trig_i | pend_q);
  assign finish = busy_q & done_i;
  assign last   = finish & (cnt_q == CNT_W'(1));

  always_comb begin
    en_d = en_q;
    if (en_we_i) en_d = en_wdata_i;
    if (last)    en_d = 1'b0;

    busy_d = busy_q;
    if (accept)      busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;

    pend_d = pend_q;
    if (accept)                   pend_d = 1'b0;
    if (busy_q & trig_i & ~last)  pend_d = 1'b1;
    if (!en_d)                    pend_d = 1'b0;

    cnt_d = cnt_q;
    if (cnt_we_i)    cnt_d = cnt_wdata_i;
    else if (finish) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_d;
      busy_q <= busy_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign en_o      = en_q;
  assign busy_o    = busy_q;
  assign cnt_o     = cnt_q;
  assign step_o    = finish;
  assign blk_end_o = last;
  assign snap_o    = en_we_i & en_wdata_i & ~en_q;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          trig_i,
  input  logic          xfer_done_i,
  output logic          xfer_req_o,
  output logic [AW-1:0] xfer_src_o,
  output logic [AW-1:0] xfer_dst_o,
  output logic [1:0]    xfer_size_o,
  output logic          xfer_dual_o,
  output logic          busy_o,
  output logic          en_o
);
  chan_cfg_t        cfg_q;
  logic             en, busy, step, blk_end, snap, unlocked;
  logic [CNT_W-1:0] cnt;

  assign unlocked = wr_en_i & ~en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cfg_q <= '0;
    else if (unlocked && wr_sel_i == SEL_CFG)   cfg_q <= chan_cfg_t'(wr_data_i[CFG_W-1:0]);
  end

  dma_chan_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_we_i     (wr_en_i && wr_sel_i == SEL_EN),
    .en_wdata_i  (wr_data_i[0]),
    .cnt_we_i    (unlocked && wr_sel_i == SEL_CNT),
    .cnt_wdata_i (wr_data_i[CNT_W-1:0]),
    .trig_i      (trig_i),
    .done_i      (xfer_done_i),
    .en_o        (en),
    .busy_o      (busy),
    .cnt_o       (cnt),
    .step_o      (step),
    .blk_end_o   (blk_end),
    .snap_o      (snap)
  );

  dma_addr_unit #(.AW(AW)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (unlocked && wr_sel_i == SEL_SRC),
    .load_val_i (wr_data_i),
    .snap_i     (snap),
    .step_i     (step),
    .blk_end_i  (blk_end),
    .mode_i     (cfg_q.src_mode),
    .size_i     (cfg_q.size),
    .addr_o     (xfer_src_o)
  );

  // single-address mode: destination never moves
  dma_addr_unit #(.AW(AW)) u_dst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (unlocked && wr_sel_i == SEL_DST),
    .load_val_i (wr_data_i),
    .snap_i     (snap),
    .step_i     (step & cfg_q.dual),
    .blk_end_i  (blk_end),
    .mode_i     (cfg_q.dst_mode),
    .size_i     (cfg_q.size),
    .addr_o     (xfer_dst_o)
  );

  assign xfer_req_o  = busy;
  assign xfer_size_o = cfg_q.size;
  assign xfer_dual_o = cfg_q.dual;
  assign busy_o      = busy;
  assign en_o        = en;
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             xfer_done_i,
  input logic             busy_o,
  input logic             en_o,
  input logic             xfer_dual_o,
  input logic [AW-1:0]    xfer_src_o,
  input logic [AW-1:0]    xfer_dst_o,
  input amode_e           src_mode,
  input logic [CNT_W-1:0] cnt
);
  AST_START_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(en_o)); // R7
  AST_IDLE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o && !busy_o |=> !busy_o); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && xfer_done_i |=> !busy_o); // R12
  AST_DESC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && en_o && !xfer_done_i |=> $stable(xfer_src_o) && $stable(xfer_dst_o)); // R8
  AST_FIXED_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && en_o && xfer_done_i && src_mode == AM_FIXED |=> $stable(xfer_src_o)); // R2
  AST_SINGLE_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && en_o && xfer_done_i && !xfer_dual_o |=> $stable(xfer_dst_o)); // R10
  AST_LAST_CLEARS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && xfer_done_i && cnt == CNT_W'(1) |=> !en_o); // R9
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.AW(AW), .CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .xfer_done_i (xfer_done_i),
  .busy_o      (busy_o),
  .en_o        (en_o),
  .xfer_dual_o (xfer_dual_o),
  .xfer_src_o  (xfer_src_o),
  .xfer_dst_o  (xfer_dst_o),
  .src_mode    (cfg_q.src_mode),
  .cnt         (cnt)
);

// File: tb/test_dma_chan_ctrl.sv
module test_dma_chan_ctrl;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [2:0]    wr_sel_i = '0;
  logic [AW-1:0] wr_data_i = '0;
  logic          trig_i = 1'b0;
  logic          xfer_done_i = 1'b0;
  logic          xfer_req_o, xfer_dual_o, busy_o, en_o;
  logic [AW-1:0] xfer_src_o, xfer_dst_o;
  logic [1:0]    xfer_size_o;

  int n_chk = 0;
  int n_fail = 0;
  bit seen = 1'b0;
  int lat = 0;

  typedef struct packed {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [1:0]    size;
    logic          dual;
  } item_t;
  item_t exp_q[$];

  always #10 clk_i = ~clk_i;

  dma_chan_ctrl i_dma_chan_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .trig_i, .xfer_done_i,
    .xfer_req_o, .xfer_src_o, .xfer_dst_o, .xfer_size_o, .xfer_dual_o,
    .busy_o, .en_o
  );

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [AW-1:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic push(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [1:0] sz, input logic du);
    item_t it;
    it.src = s; it.dst = d; it.size = sz; it.dual = du;
    exp_q.push_back(it);
  endtask

  task automatic pulse_trig();
    @(negedge clk_i);
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int k;
    k = 0;
    while ((exp_q.size() != 0 || busy_o || seen) && k < 1000) begin
      @(negedge clk_i);
      k++;
    end
    chk(k < 1000, req, AW'(exp_q.size()), '0);
    repeat (2) @(negedge clk_i);
  endtask

  // monitor: pops expected descriptor on busy rise, answers done after 2 cycles
  initial begin
    forever begin
      @(negedge clk_i);
      if (xfer_done_i) begin
        xfer_done_i = 1'b0;
        seen = 1'b0;
        chk(!busy_o, "R12 busy low after done", AW'(busy_o), '0);
      end else if (busy_o && !seen) begin
        seen = 1'b1;
        lat = 0;
        chk(xfer_req_o, "R12 req with busy", AW'(xfer_req_o), 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected transfer", xfer_src_o, '0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(xfer_src_o == e.src, "R2-5 src", xfer_src_o, e.src);
          chk(xfer_dst_o == e.dst, "R2-5 dst", xfer_dst_o, e.dst);
          chk(xfer_size_o == e.size, "R6 size", AW'(xfer_size_o), AW'(e.size));
          chk(xfer_dual_o == e.dual, "R10 dual", AW'(xfer_dual_o), AW'(e.dual));
        end
      end else if (seen) begin
        lat++;
        chk(busy_o, "R12 busy held", AW'(busy_o), 1);
        if (lat >= 2) xfer_done_i = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!en_o, "R1 en", AW'(en_o), 0);
    chk(!busy_o, "R1 busy", AW'(busy_o), 0);
    chk(xfer_src_o == 0 && xfer_dst_o == 0, "R1 addr", xfer_src_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R7: trigger while disabled is ignored
    pulse_trig();
    repeat (4) @(negedge clk_i);
    chk(!busy_o, "R7 disabled trigger", AW'(busy_o), 0);

    // R5 src inc, R3 dst dec, R6 2-byte step, dual
    wr(3'd0, 32'h100); wr(3'd1, 32'h200); wr(3'd3, 32'h57); wr(3'd2, 32'd3);
    wr(3'd4, 32'd1);
    chk(en_o, "R7 enable set", AW'(en_o), 1);
    push(32'h100, 32'h200, 2'b01, 1'b1); pulse_trig(); wait_idle("R5 xfer1");
    push(32'h102, 32'h1FE, 2'b01, 1'b1); pulse_trig(); wait_idle("R3 xfer2");
    push(32'h104, 32'h1FC, 2'b01, 1'b1); pulse_trig(); wait_idle("R6 xfer3");
    chk(!en_o, "R9 auto clear", AW'(en_o), 0);
    pulse_trig();
    repeat (4) @(negedge clk_i);
    chk(!busy_o, "R9 trigger after clear", AW'(busy_o), 0);
    // no reload in modes 11 and 01
    wr(3'd2, 32'd1); wr(3'd4, 32'd1);
    push(32'h106, 32'h1FA, 2'b01, 1'b1); pulse_trig(); wait_idle("R5 R3 no reload");

    // R2 src fixed, R4 dst inc-reload, 4-byte step, R8 lock
    wr(3'd0, 32'h1000); wr(3'd1, 32'h2000); wr(3'd3, 32'h68); wr(3'd2, 32'd2);
    wr(3'd4, 32'd1);
    wr(3'd0, 32'h5555); wr(3'd2, 32'h10); wr(3'd3, 32'h00);
    push(32'h1000, 32'h2000, 2'b10, 1'b1); pulse_trig(); wait_idle("R8 lock xfer1");
    push(32'h1000, 32'h2004, 2'b10, 1'b1); pulse_trig(); wait_idle("R2 xfer2");
    chk(!en_o, "R8 count write ignored", AW'(en_o), 0);
    wr(3'd2, 32'd1); wr(3'd4, 32'd1);
    push(32'h1000, 32'h2000, 2'b10, 1'b1); pulse_trig(); wait_idle("R4 reload");

    // R10 single mode, 1-byte step
    wr(3'd0, 32'h40); wr(3'd1, 32'h300); wr(3'd3, 32'h0F); wr(3'd2, 32'd2);
    wr(3'd4, 32'd1);
    push(32'h40, 32'h300, 2'b00, 1'b0); pulse_trig(); wait_idle("R10 xfer1");
    push(32'h41, 32'h300, 2'b00, 1'b0); pulse_trig(); wait_idle("R10 xfer2");

    // R11 pending trigger, size code 11 -> 4 bytes
    wr(3'd0, 32'h80); wr(3'd1, 32'h0); wr(3'd3, 32'h73); wr(3'd2, 32'd3);
    wr(3'd4, 32'd1);
    push(32'h80, 32'h0, 2'b11, 1'b1);
    push(32'h84, 32'h0, 2'b11, 1'b1);
    pulse_trig();
    while (!busy_o) @(negedge clk_i);
    pulse_trig();
    wait_idle("R11 pending served");
    chk(en_o, "R11 still enabled", AW'(en_o), 1);
    push(32'h88, 32'h0, 2'b11, 1'b1); pulse_trig(); wait_idle("R11 xfer3");
    chk(!en_o, "R9 clear after pending", AW'(en_o), 0);

    // R8: disable by writing 0 at any time
    wr(3'd2, 32'd5); wr(3'd4, 32'd1); wr(3'd4, 32'd0);
    pulse_trig();
    repeat (4) @(negedge clk_i);
    chk(!busy_o && !en_o, "R8 enable write 0", AW'(busy_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule